// File: doc/BRIEF.md
# Segment Descriptor Load Checker

This block performs the work behind writing a new selector into a segment register. The caller presents a selector, the kind of segment being loaded (data, stack or code), the mode bits, the current privilege level and the bases and limits of the global and local descriptor tables. In real-address or virtual-8086 operation the block derives the segment base straight from the selector and touches no memory.

In protected operation the block first checks the selector against the limit of the chosen table. It then fetches the 8-byte descriptor through a simple request/acknowledge read port and applies the privilege and type rules that belong to the target kind. The result is either an updated cached descriptor (selector, base, limit, attributes, requested privilege) or a fault kind together with an error code.

A successful code load also hands back the new current privilege level for the caller to store. Gate descriptors are not decoded: a system-type descriptor is simply refused.

Top module: `seg_load_unit`

## Requirements
- R1: When protection is off, or virtual-8086 is set, an accepted load sets the cached selector to the selector and the cached base to the selector times 16. It issues no memory read, raises no fault and leaves the cached limit and attributes unchanged.
- R2: In protected operation, selector bit 2 chooses the local table (set) or the global table (clear). The descriptor is read as two 32-bit words: the low word at table base plus (selector AND 0xFFF8), then the high word 4 bytes above it. The address is held steady until each acknowledge.
- R3: If (selector AND 0xFFF8) exceeds the chosen table limit, the load ends with a general-protection fault whose code is the selector, and no read is issued. Fault kind encoding: 0 none, 1 general-protection, 2 stack, 3 not-present.
- R4: A stack load (kind 1) with a null index (selector bits 15:3 zero) gives general-protection with code 0 and no read. A stack load also gives general-protection with the selector as code when the descriptor is a system type (bit 44 clear), is executable (bit 43), or is not writable (bit 41). The same applies when RPL (selector bits 1:0) differs from the current level or from the DPL (bits 46:45).
- R5: A stack load that passes R4 but whose descriptor has the present bit (bit 47) clear gives a stack fault with the selector as code.
- R6: A code load (kind 2) with a null index gives general-protection with code 0. Otherwise the checks run in this order: a system type gives general-protection, a clear present bit gives not-present, and a non-executable descriptor gives general-protection. Each of these faults carries the selector as code.
- R7: For conforming code (bit 42 set), a DPL above the current level is a general-protection fault. For non-conforming code, an RPL above the current level, or a current level different from the DPL, is a general-protection fault.
- R8: A successful code load pulses cpl_we_o together with done_o, with cpl_new_o equal to the selector RPL. No other load pulses cpl_we_o.
- R9: A data load (kind 0, kind 3 behaves the same) with a null index is accepted without a read. It stores the selector and its RPL, and zeroes the cached base, limit and attributes.
- R10: A non-null data load gives general-protection for a system type, or when RPL or the current level exceeds the DPL. Otherwise it gives not-present when the present bit is clear. All these faults carry the selector as code.
- R11: On success, the cached base is bits {63:56, 39:32, 31:16} and the cached limit is {51:48, 15:0}. When the granularity bit (bit 55) is set, the limit is shifted left by 12. The cached attributes are {bit 54, 47, 46:45, 44, 43, 42, 41, 40}, most significant first.
- R12: A faulting load leaves every cached descriptor field unchanged. Each load ends with done_o high for exactly one cycle, with fault_o high in that cycle only if the load failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a load; taken when busy_o is low |
| selector_i | input | SEL_W | Selector to load |
| seg_kind_i | input | 2 | 0 data, 1 stack, 2 code |
| prot_en_i | input | 1 | Protected operation enabled |
| v86_i | input | 1 | Virtual-8086 operation |
| cpl_i | input | 2 | Current privilege level |
| gtab_base_i | input | ADDR_W | Global table base |
| gtab_limit_i | input | TLIM_W | Global table limit |
| ltab_base_i | input | ADDR_W | Local table base |
| ltab_limit_i | input | TLIM_W | Local table limit |
| busy_o | output | 1 | Load in progress |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | ADDR_W | Descriptor read address |
| mem_ack_i | input | 1 | Read data valid |
| mem_data_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle end-of-load pulse |
| fault_o | output | 1 | Load failed (with done_o) |
| fault_kind_o | output | 2 | Fault kind of the last load |
| fault_code_o | output | SEL_W | Error code of the last fault |
| cpl_we_o | output | 1 | Update current privilege level |
| cpl_new_o | output | 2 | New current privilege level |
| cache_sel_o | output | SEL_W | Cached selector |
| cache_base_o | output | ADDR_W | Cached base |
| cache_limit_o | output | 32 | Cached limit |
| cache_attr_o | output | 9 | Cached attributes |
| cache_rpl_o | output | 2 | Cached requested privilege |

## Verification
Several properties are checked on every cycle. Real-mode and virtual-8086 loads must give the shifted base one cycle later with no read. An out-of-range index must give a general-protection fault carrying the selector. A stack fault may only end a stack load, and a not-present fault never does. The read address must stay stable while a read is unacknowledged, a privilege update may only accompany a successful code load, and a fault must leave the cache untouched. The rule ordering is shown only by the bench's directed descriptors and expected values. This covers conforming versus non-conforming privilege, the null-index codes, the granularity shift, field assembly and the choice of table.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;

  typedef enum logic [1:0] {
    SEG_DATA  = 2'd0,
    SEG_STACK = 2'd1,
    SEG_CODE  = 2'd2
  } seg_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_SS   = 2'd2,
    FLT_NP   = 2'd3
  } flt_kind_e;

  typedef struct packed {
    logic       big;
    logic       present;
    logic [1:0] dpl;
    logic       sflag;
    logic       exec;
    logic       dc;
    logic       rw;
    logic       acc;
  } seg_attr_t;

  localparam int DESC_W   = 64;
  localparam int WORD_W   = 32;
  localparam int GRAN_SH  = 12;
  localparam int REAL_SH  = 4;

endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_load_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 32
) (
  input  logic [DESC_W-1:0] desc_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [LIM_W-1:0]  limit_o,
  output seg_attr_t         attr_o
);
  localparam int RAW_LIM_W = 20;

  logic [WORD_W-1:0]    lo_w, hi_w;
  logic [WORD_W-1:0]    raw_base;
  logic [RAW_LIM_W-1:0] raw_lim;
  logic                 unused_bits;

  assign lo_w     = desc_i[WORD_W-1:0];
  assign hi_w     = desc_i[DESC_W-1:WORD_W];
  assign raw_base = {hi_w[31:24], hi_w[7:0], lo_w[31:16]};
  assign raw_lim  = {hi_w[19:16], lo_w[15:0]};
  assign unused_bits = ^hi_w[21:20];

  assign base_o  = ADDR_W'(raw_base);
  assign limit_o = hi_w[23] ? LIM_W'({raw_lim, {GRAN_SH{1'b0}}}) : LIM_W'(raw_lim);

  assign attr_o = '{big:     hi_w[22],
                    present: hi_w[15],
                    dpl:     hi_w[14:13],
                    sflag:   hi_w[12],
                    exec:    hi_w[11],
                    dc:      hi_w[10],
                    rw:      hi_w[9],
                    acc:     hi_w[8]};
endmodule

// File: rtl/seg_rule_check.sv
module seg_rule_check
  import seg_load_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  seg_kind_e        kind_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       cpl_i,
  input  seg_attr_t        attr_i,
  output flt_kind_e        flt_o,
  output logic [SEL_W-1:0] code_o
);
  logic       null_sel;
  logic [1:0] rpl;

  assign null_sel = (sel_i[SEL_W-1:3] == '0);
  assign rpl      = sel_i[1:0];

  always_comb begin
    flt_o  = FLT_NONE;
    code_o = sel_i;
    case (kind_i)
      SEG_STACK: begin
        if (null_sel) begin
          flt_o  = FLT_GP;
          code_o = '0;
        end else if (!attr_i.sflag || attr_i.exec || !attr_i.rw ||
                     rpl != cpl_i || rpl != attr_i.dpl) begin
          flt_o = FLT_GP;
        end else if (!attr_i.present) begin
          flt_o = FLT_SS;
        end
      end
      SEG_CODE: begin
        if (null_sel) begin
          flt_o  = FLT_GP;
          code_o = '0;
        end else if (!attr_i.sflag) begin
          flt_o = FLT_GP;   // gates are refused
        end else if (!attr_i.present) begin
          flt_o = FLT_NP;
        end else if (!attr_i.exec) begin
          flt_o = FLT_GP;
        end else if (attr_i.dc ? (attr_i.dpl > cpl_i)
                               : (rpl > cpl_i || cpl_i != attr_i.dpl)) begin
          flt_o = FLT_GP;
        end
      end
      default: begin
        if (!null_sel) begin
          if (!attr_i.sflag) begin
            flt_o = FLT_GP;
          end else if (rpl > attr_i.dpl || cpl_i > attr_i.dpl) begin
            flt_o = FLT_GP;
          end else if (!attr_i.present) begin
            flt_o = FLT_NP;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
  import seg_load_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16,
  parameter int SEL_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [SEL_W-1:0]  selector_i,
  input  logic [1:0]        seg_kind_i,
  input  logic              prot_en_i,
  input  logic              v86_i,
  input  logic [1:0]        cpl_i,
  input  logic [ADDR_W-1:0] gtab_base_i,
  input  logic [TLIM_W-1:0] gtab_limit_i,
  input  logic [ADDR_W-1:0] ltab_base_i,
  input  logic [TLIM_W-1:0] ltab_limit_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_data_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_kind_o,
  output logic [SEL_W-1:0]  fault_code_o,
  output logic              cpl_we_o,
  output logic [1:0]        cpl_new_o,
  output logic [SEL_W-1:0]  cache_sel_o,
  output logic [ADDR_W-1:0] cache_base_o,
  output logic [31:0]       cache_limit_o,
  output logic [8:0]        cache_attr_o,
  output logic [1:0]        cache_rpl_o
);
  localparam int CMP_W    = ((SEL_W > TLIM_W) ? SEL_W : TLIM_W) + 1;
  localparam int HI_OFS   = WORD_W / 8;
  localparam int LIM_W    = 32;

  typedef enum logic [1:0] {S_IDLE, S_FETCH_LO, S_FETCH_HI, S_EVAL} state_e;

  state_e              state_q;
  logic [SEL_W-1:0]    sel_q;
  seg_kind_e           kind_q;
  logic [1:0]          cpl_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [WORD_W-1:0]   lo_q, hi_q;
  logic                done_q, fault_q, cpl_we_q;
  flt_kind_e           fkind_q;
  logic [SEL_W-1:0]    fcode_q;
  logic [1:0]          cpl_new_q;
  logic [SEL_W-1:0]    c_sel_q;
  logic [ADDR_W-1:0]   c_base_q;
  logic [LIM_W-1:0]    c_lim_q;
  seg_attr_t           c_attr_q;
  logic [1:0]          c_rpl_q;

  // request-side decode
  logic                prot_mode;
  logic                use_local;
  logic [SEL_W-1:0]    sel_off;
  logic [CMP_W-1:0]    off_ext, lim_ext;
  logic                idx_over;
  logic                idx_null;
  logic [ADDR_W-1:0]   tab_base;

  assign prot_mode = prot_en_i && !v86_i;
  assign use_local = selector_i[2];
  assign sel_off   = {selector_i[SEL_W-1:3], 3'b000};
  assign off_ext   = CMP_W'(sel_off);
  assign lim_ext   = use_local ? CMP_W'(ltab_limit_i) : CMP_W'(gtab_limit_i);
  assign idx_over  = off_ext > lim_ext;
  assign idx_null  = (selector_i[SEL_W-1:3] == '0);
  assign tab_base  = use_local ? ltab_base_i : gtab_base_i;

  // descriptor decode and rule check
  logic [ADDR_W-1:0] d_base;
  logic [LIM_W-1:0]  d_lim;
  seg_attr_t         d_attr;
  flt_kind_e         chk_flt;
  logic [SEL_W-1:0]  chk_code;

  seg_desc_unpack #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_unpack (
    .desc_i  ({hi_q, lo_q}),
    .base_o  (d_base),
    .limit_o (d_lim),
    .attr_o  (d_attr)
  );

  seg_rule_check #(.SEL_W(SEL_W)) u_check (
    .kind_i (kind_q),
    .sel_i  (sel_q),
    .cpl_i  (cpl_q),
    .attr_i (d_attr),
    .flt_o  (chk_flt),
    .code_o (chk_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      sel_q     <= '0;
      kind_q    <= SEG_DATA;
      cpl_q     <= '0;
      addr_q    <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      cpl_we_q  <= 1'b0;
      fkind_q   <= FLT_NONE;
      fcode_q   <= '0;
      cpl_new_q <= '0;
      c_sel_q   <= '0;
      c_base_q  <= '0;
      c_lim_q   <= '0;
      c_attr_q  <= '0;
      c_rpl_q   <= '0;
    end else begin
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      cpl_we_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid_i) begin
            sel_q  <= selector_i;
            kind_q <= seg_kind_e'(seg_kind_i);
            cpl_q  <= v86_i ? 2'd3 : cpl_i;
            if (!prot_mode) begin
              c_sel_q  <= selector_i;
              c_base_q <= ADDR_W'({selector_i, {REAL_SH{1'b0}}});
              done_q   <= 1'b1;
              fkind_q  <= FLT_NONE;
            end else if (idx_over) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              fkind_q <= FLT_GP;
              fcode_q <= selector_i;
            end else if (idx_null) begin
              // null index: evaluate against an all-zero descriptor
              lo_q    <= '0;
              hi_q    <= '0;
              state_q <= S_EVAL;
            end else begin
              addr_q  <= tab_base + ADDR_W'(sel_off);
              state_q <= S_FETCH_LO;
            end
          end
        end
        S_FETCH_LO: begin
          if (mem_ack_i) begin
            lo_q    <= mem_data_i;
            state_q <= S_FETCH_HI;
          end
        end
        S_FETCH_HI: begin
          if (mem_ack_i) begin
            hi_q    <= mem_data_i;
            state_q <= S_EVAL;
          end
        end
        default: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
          if (chk_flt != FLT_NONE) begin
            fault_q <= 1'b1;
            fkind_q <= chk_flt;
            fcode_q <= chk_code;
          end else begin
            fkind_q  <= FLT_NONE;
            c_sel_q  <= sel_q;
            c_base_q <= d_base;
            c_lim_q  <= d_lim;
            c_attr_q <= d_attr;
            c_rpl_q  <= sel_q[1:0];
            if (kind_q == SEG_CODE) begin
              cpl_we_q  <= 1'b1;
              cpl_new_q <= sel_q[1:0];
            end
          end
        end
      endcase
    end
  end

  assign busy_o        = (state_q != S_IDLE);
  assign mem_req_o     = (state_q == S_FETCH_LO) || (state_q == S_FETCH_HI);
  assign mem_addr_o    = (state_q == S_FETCH_HI) ? addr_q + ADDR_W'(HI_OFS) : addr_q;
  assign done_o        = done_q;
  assign fault_o       = fault_q;
  assign fault_kind_o  = fkind_q;
  assign fault_code_o  = fcode_q;
  assign cpl_we_o      = cpl_we_q;
  assign cpl_new_o     = cpl_new_q;
  assign cache_sel_o   = c_sel_q;
  assign cache_base_o  = c_base_q;
  assign cache_limit_o = c_lim_q;
  assign cache_attr_o  = c_attr_q;
  assign cache_rpl_o   = c_rpl_q;

  // ---------------- assertions ----------------
  p_real_base_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && req_valid_i && !prot_mode) |=>
      (done_o && !fault_o && !mem_req_o &&
       cache_base_o == ADDR_W'({$past(selector_i), {REAL_SH{1'b0}}})));

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_bound_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && req_valid_i && prot_mode && idx_over) |=>
      (fault_o && fault_kind_o == FLT_GP && fault_code_o == $past(selector_i)));

  p_ss_stack_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o && fault_kind_o == FLT_SS) |-> (kind_q == SEG_STACK));

  p_np_not_stack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o && fault_kind_o == FLT_NP) |-> (kind_q != SEG_STACK));

  p_cpl_code_ok_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_we_o |-> (done_o && !fault_o && kind_q == SEG_CODE && cpl_new_o == cache_rpl_o));

  p_fault_keeps_cache_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> ($stable(cache_base_o) && $stable(cache_sel_o) &&
                             $stable(cache_limit_o) && $stable(cache_attr_o)));

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_fault_with_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);

endmodule

// File: tb/sim_seg_load_unit.sv
module sim_seg_load_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [15:0] selector_i = '0;
  logic [1:0]  seg_kind_i = '0;
  logic        prot_en_i = 1'b0;
  logic        v86_i = 1'b0;
  logic [1:0]  cpl_i = '0;
  logic [31:0] gtab_base_i = 32'h0000_1000;
  logic [15:0] gtab_limit_i = 16'h007F;
  logic [31:0] ltab_base_i = 32'h0000_1200;
  logic [15:0] ltab_limit_i = 16'h000F;
  logic        busy_o, mem_req_o, done_o, fault_o, cpl_we_o;
  logic [31:0] mem_addr_o, cache_base_o, cache_limit_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_data_i = '0;
  logic [1:0]  fault_kind_o, cpl_new_o, cache_rpl_o;
  logic [15:0] fault_code_o, cache_sel_o;
  logic [8:0]  cache_attr_o;

  always #4 clk_i = ~clk_i;

  seg_load_unit u0 (.*);

  // descriptor memory model, one-cycle acknowledge
  logic [31:0] dmem [0:255];
  logic [31:0] log_addr [0:7];
  int unsigned rd_total = 0;

  always @(posedge clk_i) begin
    mem_ack_i  <= mem_req_o && !mem_ack_i;
    mem_data_i <= dmem[mem_addr_o[9:2]];
    if (mem_req_o && mem_ack_i) begin
      log_addr[rd_total[2:0]] <= mem_addr_o;
      rd_total <= rd_total + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  // load results
  logic        r_fault, r_we;
  logic [1:0]  r_kind, r_new;
  logic [15:0] r_code;
  int          r_reads;
  logic [31:0] r_a0, r_a1;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_desc(input logic [31:0] b, input logic [19:0] l,
      input logic [3:0] ty, input logic s, input logic [1:0] dpl,
      input logic p, input logic db, input logic g);
    mk_desc = {b[31:24], g, db, 2'b00, l[19:16], p, dpl, s, ty, b[23:16], b[15:0], l[15:0]};
  endfunction

  task automatic put_desc(input logic [31:0] tbase, input int idx, input logic [63:0] d);
    logic [31:0] a;
    a = tbase + 32'(idx * 8);
    dmem[a[9:2]]        = d[31:0];
    dmem[a[9:2] + 8'd1] = d[63:32];
  endtask

  task automatic do_load(input logic [15:0] sel, input logic [1:0] kind,
                         input logic prot, input logic v86, input logic [1:0] cpl);
    int start, guard;
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    start = rd_total;
    selector_i = sel; seg_kind_i = kind; prot_en_i = prot; v86_i = v86; cpl_i = cpl;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    guard = 0;
    while (!done_o && guard < 50) begin
      @(negedge clk_i);
      guard++;
    end
    r_fault = fault_o; r_kind = fault_kind_o; r_code = fault_code_o;
    r_we = cpl_we_o; r_new = cpl_new_o;
    r_reads = rd_total - start;
    r_a0 = log_addr[start[2:0]];
    r_a1 = log_addr[3'(start + 1)];
    chk("R12", "done pulse", done_o, 1'b1);
  endtask

  task automatic expect_fault(input string req, input logic [1:0] k, input logic [15:0] c);
    chk(req, "fault", r_fault, 1'b1);
    chk(req, "fault kind", r_kind, k);
    chk(req, "fault code", r_code, c);
    chk("R8", "no cpl write on fault", r_we, 1'b0);
  endtask

  task automatic t_reset();
    chk("R12", "reset done", done_o, 1'b0);
    chk("R2", "reset mem_req", mem_req_o, 1'b0);
    chk("R12", "reset cache base", cache_base_o, 32'h0);
    chk("R12", "reset busy", busy_o, 1'b0);
  endtask

  task automatic t_real();
    do_load(16'h1234, 2'd0, 1'b0, 1'b0, 2'd0);
    chk("R1", "real no fault", r_fault, 1'b0);
    chk("R1", "real base", cache_base_o, 32'h0001_2340);
    chk("R1", "real sel", cache_sel_o, 16'h1234);
    chk("R1", "real reads", r_reads, 0);
    chk("R1", "real limit kept", cache_limit_o, 32'h0);
    do_load(16'hABCD, 2'd1, 1'b1, 1'b1, 2'd0);
    chk("R1", "v86 base", cache_base_o, 32'h000A_BCD0);
    chk("R1", "v86 reads", r_reads, 0);
    chk("R1", "v86 no fault", r_fault, 1'b0);
  endtask

  task automatic t_data_ok();
    do_load(16'h0010, 2'd0, 1'b1, 1'b0, 2'd0);
    chk("R10", "data ok", r_fault, 1'b0);
    chk("R2", "read count", r_reads, 2);
    chk("R2", "low word addr", r_a0, 32'h0000_1010);
    chk("R2", "high word addr", r_a1, 32'h0000_1014);
    chk("R11", "base", cache_base_o, 32'h1234_5678);
    chk("R11", "limit", cache_limit_o, 32'h000A_BCDE);
    chk("R11", "attr", cache_attr_o, 9'h1F2);
    chk("R8", "data no cpl write", r_we, 1'b0);
    do_load(16'h0013, 2'd0, 1'b1, 1'b0, 2'd3);
    chk("R10", "rpl=cpl=dpl ok", r_fault, 1'b0);
    chk("R11", "rpl cached", cache_rpl_o, 2'd3);
    do_load(16'h0018, 2'd0, 1'b1, 1'b0, 2'd0);
    chk("R11", "granular limit", cache_limit_o, 32'h0001_2000);
    chk("R11", "granular base", cache_base_o, 32'h0000_1000);
  endtask

  task automatic t_local();
    do_load(16'h000C, 2'd0, 1'b1, 1'b0, 2'd0);
    chk("R2", "local ok", r_fault, 1'b0);
    chk("R2", "local low addr", r_a0, 32'h0000_1208);
    chk("R2", "local high addr", r_a1, 32'h0000_120C);
    chk("R2", "local base", cache_base_o, 32'h00AB_C000);
  endtask

  task automatic t_bounds();
    logic [31:0] keep;
    keep = cache_base_o;
    do_load(16'h0080, 2'd0, 1'b1, 1'b0, 2'd0);
    expect_fault("R3", 2'd1, 16'h0080);
    chk("R3", "no read", r_reads, 0);
    do_load(16'h0014, 2'd0, 1'b1, 1'b0, 2'd0);
    expect_fault("R3", 2'd1, 16'h0014);
    chk("R12", "cache kept", cache_base_o, keep);
  endtask

  task automatic t_stack();
    do_load(16'h0020, 2'd1, 1'b1, 1'b0, 2'd0);
    chk("R4", "stack ok", r_fault, 1'b0);
    chk("R4", "stack base", cache_base_o, 32'h0040_0000);
    do_load(16'h0023, 2'd1, 1'b1, 1'b0, 2'd0);
    expect_fault("R4", 2'd1, 16'h0023);
    do_load(16'h0023, 2'd1, 1'b1, 1'b0, 2'd3);
    expect_fault("R4", 2'd1, 16'h0023);
    do_load(16'h0003, 2'd1, 1'b1, 1'b0, 2'd3);
    expect_fault("R4", 2'd1, 16'h0000);
    chk("R4", "null no read", r_reads, 0);
    do_load(16'h0028, 2'd1, 1'b1, 1'b0, 2'd0);
    expect_fault("R4", 2'd1, 16'h0028);
    do_load(16'h0038, 2'd1, 1'b1, 1'b0, 2'd0);
    expect_fault("R4", 2'd1, 16'h0038);
    do_load(16'h0030, 2'd1, 1'b1, 1'b0, 2'd0);
    expect_fault("R5", 2'd2, 16'h0030);
    chk("R12", "stack cache sel kept", cache_sel_o, 16'h0020);
    chk("R12", "stack cache base kept", cache_base_o, 32'h0040_0000);
  endtask

  task automatic t_code();
    do_load(16'h0040, 2'd2, 1'b1, 1'b0, 2'd0);
    chk("R6", "code ok", r_fault, 1'b0);
    chk("R8", "cpl write", r_we, 1'b1);
    chk("R8", "cpl value", r_new, 2'd0);
    chk("R6", "code base", cache_base_o, 32'h0080_0000);
    do_load(16'h0043, 2'd2, 1'b1, 1'b0, 2'd0);
    expect_fault("R7", 2'd1, 16'h0043);
    do_load(16'h0040, 2'd2, 1'b1, 1'b0, 2'd3);
    expect_fault("R7", 2'd1, 16'h0040);
    do_load(16'h004B, 2'd2, 1'b1, 1'b0, 2'd3);
    chk("R7", "conforming ok", r_fault, 1'b0);
    chk("R8", "conforming cpl write", r_we, 1'b1);
    chk("R8", "conforming cpl value", r_new, 2'd3);
    do_load(16'h0050, 2'd2, 1'b1, 1'b0, 2'd0);
    expect_fault("R7", 2'd1, 16'h0050);
    do_load(16'h0058, 2'd2, 1'b1, 1'b0, 2'd0);
    expect_fault("R6", 2'd3, 16'h0058);
    do_load(16'h0020, 2'd2, 1'b1, 1'b0, 2'd0);
    expect_fault("R6", 2'd1, 16'h0020);
    do_load(16'h0038, 2'd2, 1'b1, 1'b0, 2'd0);
    expect_fault("R6", 2'd1, 16'h0038);
    do_load(16'h0000, 2'd2, 1'b1, 1'b0, 2'd0);
    expect_fault("R6", 2'd1, 16'h0000);
    chk("R12", "code cache kept", cache_sel_o, 16'h004B);
  endtask

  task automatic t_data_fail();
    do_load(16'h0060, 2'd0, 1'b1, 1'b0, 2'd3);
    expect_fault("R10", 2'd1, 16'h0060);
    do_load(16'h0063, 2'd0, 1'b1, 1'b0, 2'd0);
    expect_fault("R10", 2'd1, 16'h0063);
    do_load(16'h0068, 2'd0, 1'b1, 1'b0, 2'd0);
    expect_fault("R10", 2'd3, 16'h0068);
    do_load(16'h0038, 2'd0, 1'b1, 1'b0, 2'd0);
    expect_fault("R10", 2'd1, 16'h0038);
    do_load(16'h0002, 2'd0, 1'b1, 1'b0, 2'd3);
    chk("R9", "null data ok", r_fault, 1'b0);
    chk("R9", "null no read", r_reads, 0);
    chk("R9", "null base", cache_base_o, 32'h0);
    chk("R9", "null limit", cache_limit_o, 32'h0);
    chk("R9", "null attr", cache_attr_o, 9'h0);
    chk("R9", "null sel", cache_sel_o, 16'h0002);
    chk("R9", "null rpl", cache_rpl_o, 2'd2);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) dmem[i] = '0;
    for (int i = 0; i < 8; i++) log_addr[i] = '0;
    put_desc(32'h1000, 2,  mk_desc(32'h1234_5678, 20'hABCDE, 4'b0010, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0));
    put_desc(32'h1000, 3,  mk_desc(32'h0000_1000, 20'h00012, 4'b0010, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1));
    put_desc(32'h1200, 1,  mk_desc(32'h00AB_C000, 20'h0FFFF, 4'b0010, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0));
    put_desc(32'h1000, 4,  mk_desc(32'h0040_0000, 20'h0FFFF, 4'b0010, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0));
    put_desc(32'h1000, 5,  mk_desc(32'h0050_0000, 20'h0FFFF, 4'b1010, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0));
    put_desc(32'h1000, 6,  mk_desc(32'h0060_0000, 20'h0FFFF, 4'b0010, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0));
    put_desc(32'h1000, 7,  mk_desc(32'h0070_0000, 20'h0FFFF, 4'b0010, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0));
    put_desc(32'h1000, 8,  mk_desc(32'h0080_0000, 20'h0FFFF, 4'b1010, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0));
    put_desc(32'h1000, 9,  mk_desc(32'h0090_0000, 20'h0FFFF, 4'b1110, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0));
    put_desc(32'h1000, 10, mk_desc(32'h00A0_0000, 20'h0FFFF, 4'b1110, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0));
    put_desc(32'h1000, 11, mk_desc(32'h00B0_0000, 20'h0FFFF, 4'b1010, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0));
    put_desc(32'h1000, 12, mk_desc(32'h00C0_0000, 20'h0FFFF, 4'b0010, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0));
    put_desc(32'h1000, 13, mk_desc(32'h00D0_0000, 20'h0FFFF, 4'b0010, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_real();
    t_data_ok();
    t_local();
    t_bounds();
    t_stack();
    t_code();
    t_data_fail();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule